// File: doc/BRIEF.md
# Serial-Flash Page Program-and-Verify Sequencer

This block turns one "write N bytes starting at byte address A" request into the ordered series of byte-level command frames that a page-organised serial flash needs. It splits the byte range at page boundaries, and handles each page through the device's first on-chip SRAM buffer. For a partial page, it first loads the buffer from the array so that the untouched bytes survive. It then sends a program-through-buffer frame that carries the payload. If enabled, it follows with a buffer-against-array compare. After every one of these commands it polls the device status until the device reports ready.

Page size and the page-address shift are run-time configuration inputs, so one instance can serve devices with power-of-two and non-power-of-two pages. Payload bytes arrive on a valid/ready stream and are passed straight into the program frame. Frames leave on a byte-request interface towards an SPI shifter, which is outside this block. The shifter acknowledges each byte and returns the byte it clocked in. It drops chip select after the byte that is marked last.

On completion the block pulses `done` and holds the result. This covers two error flags, the failing page number and the number of bytes written successfully.

Top module: `dfprog_seq`

## Requirements
- R1: A request with `reqLen` = 0 raises `done` in the cycle after `start`. It issues no frame, reports `bytesWritten` = 0 and leaves both error flags low.
- R2: A request with `startAddr + reqLen > devSize` raises `done` in the cycle after `start` with `rangeErr` = 1 and issues no frame. A range that ends exactly at `devSize` is accepted.
- R3: The first chunk is min(`reqLen`, `pageSize` − (`startAddr` mod `pageSize`)). Each later chunk is a full page, or the final remainder, and starts at offset 0 of the next page.
- R4: Before a chunk shorter than `pageSize`, and only then, the block sends a 4-byte frame: 0x53, then the page address (page number shifted left by `pageShift`) as three bytes, most significant first, with the last byte forced to 0x00. `pageShift` must be at least 8.
- R5: Each chunk is programmed in one frame: 0x82, then three address bytes, most significant first, of (page number << `pageShift`) + offset, then the chunk's payload bytes in stream order. `spiLast` is set only on the final payload byte.
- R6: After each 0x53, 0x82 or 0x60 frame, the block repeats 2-byte status frames (0xD7, then one dummy byte whose returned value is the status) until returned bit 7 = 1. It ignores bit 6 while bit 7 = 0. No other command frame starts before that ready status.
- R7: With `verifyEn` = 1, each programmed page is followed by a 4-byte frame 0x60 with the page address and a 0x00 last byte.
- R8: If the ready status after a compare has bit 6 = 1, the block sends no further frame. It raises `done` with `ioErr` = 1 and `failPage` = the page number of that chunk.
- R9: With `verifyEn` = 0, no 0x60 frame is sent and each page completes after its program frame turns ready.
- R10: At `done`, `bytesWritten` equals the sum of the chunks whose sequence completed. On a compare failure, the failing chunk is not counted.
- R11: `wrReady` is high only in a cycle where the payload byte on `wrData` is being acknowledged by the shifter (`spiReq` and `spiAck` high). Each accepted byte appears exactly once in a program frame.
- R12: `spiReq` is low out of reset. Once raised, `spiReq`, `spiByte` and `spiLast` hold until `spiAck`. Every frame ends with a byte carrying `spiLast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a request (accepted while idle) |
| startAddr | input | LEN_W | First linear byte address |
| reqLen | input | LEN_W | Number of bytes to write |
| devSize | input | LEN_W | Device capacity in bytes |
| pageSize | input | PSZ_W | Bytes per page |
| pageShift | input | SH_W | Left shift placing the page number in the 3-byte address |
| verifyEn | input | 1 | Enable per-page compare |
| wrData | input | 8 | Payload byte |
| wrValid | input | 1 | Payload byte valid |
| wrReady | output | 1 | Payload byte taken |
| spiReq | output | 1 | Byte exchange request to the shifter |
| spiByte | output | 8 | Byte to send |
| spiLast | output | 1 | Deselect the device after this byte |
| spiAck | input | 1 | Shifter finished the byte exchange |
| spiRx | input | 8 | Byte received during the exchange |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rangeErr | output | 1 | Request rejected as out of range |
| ioErr | output | 1 | Compare mismatch stopped the write |
| failPage | output | LEN_W | Page number that failed compare |
| bytesWritten | output | LEN_W | Bytes written successfully |

## Verification
The hardest situation to reach from the ports is a compare mismatch on a page in the middle of a range, and in the same run status bytes that carry bit 6 while the device is still busy. The bench therefore models the flash behind the shifter interface. It answers every command with two busy statuses that have bit 6 set, then a ready status. It raises the mismatch bit only on the ready status that follows the compare of one chosen page. It also checks in-line that no command frame starts while the modelled device is busy, and that payload bytes arrive in stream order.

// File: rtl/dfprog_pkg.sv
package dfprog_pkg;
  // Frame address is three bytes on the wire.
  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_FILL = 8'h53;  // array page -> buffer 1
  localparam logic [7:0] OP_PROG = 8'h82;  // buffer 1 write + erase/program
  localparam logic [7:0] OP_CMP  = 8'h60;  // buffer 1 vs array compare
  localparam logic [7:0] OP_STAT = 8'hD7;  // status read

  typedef enum logic [1:0] {PH_FILL, PH_PROG, PH_CMP} phase_t;
  typedef enum logic [1:0] {SEL_HDR, SEL_DATA, SEL_SOP, SEL_SRD} bsel_t;
  typedef enum logic [2:0] {S_IDLE, S_DIV, S_PLAN, S_HDR, S_DATA, S_POP, S_PRD, S_FIN} state_t;

  typedef struct packed {
    logic   load;
    logic   divRun;
    logic   hdrClr;
    logic   hdrNext;
    logic   dataNext;
    logic   pageAdv;
    logic   setIoErr;
    logic   setRangeErr;
    phase_t phase;
    bsel_t  sel;
  } strobe_t;
endpackage

// File: rtl/dfprog_dpath.sv
module dfprog_dpath
  import dfprog_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int PSZ_W = 12,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [LEN_W-1:0] startAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [LEN_W-1:0] devSize,
  input  logic [PSZ_W-1:0] pageSize,
  input  logic [SH_W-1:0]  pageShift,
  input  logic [7:0]       wrData,
  output logic [7:0]       spiByte,
  output logic             isZero,
  output logic             isOver,
  output logic             divDone,
  output logic             partial,
  output logic             lastChunk,
  output logic             lastHdr,
  output logic             lastData,
  output logic             ioErr,
  output logic             rangeErr,
  output logic [LEN_W-1:0] failPage,
  output logic [LEN_W-1:0] bytesWritten
);
  localparam int CNT_W = $clog2(LEN_W + 1);

  logic [LEN_W-1:0]  quo, remain, written;   // quo: dividend, then page number
  logic [PSZ_W-1:0]  rem, dataCnt, room, chunk;
  logic [CNT_W-1:0]  divCnt;
  logic [1:0]        hdrIdx;
  logic [PSZ_W:0]    trial;
  logic              takeBit;
  logic [ADDR_W-1:0] shPage, frameAddr;
  logic [7:0]        hdrByte;

  assign isZero    = (reqLen == '0);
  assign isOver    = ({1'b0, startAddr} + {1'b0, reqLen}) > {1'b0, devSize};
  assign divDone   = (divCnt == CNT_W'(LEN_W));
  assign trial     = {rem, quo[LEN_W-1]};
  assign takeBit   = (trial >= {1'b0, pageSize});
  assign room      = pageSize - rem;
  assign chunk     = (remain < LEN_W'(room)) ? remain[PSZ_W-1:0] : room;
  assign partial   = (chunk != pageSize);
  assign lastChunk = (remain == LEN_W'(chunk));
  assign lastHdr   = (hdrIdx == 2'd3);
  assign lastData  = (dataCnt == PSZ_W'(1));
  assign shPage    = ADDR_W'(quo) << pageShift;
  assign frameAddr = shPage + ((st.phase == PH_PROG) ? ADDR_W'(rem) : '0);
  assign bytesWritten = written;

  always_comb begin
    unique case (hdrIdx)
      2'd0: begin
        unique case (st.phase)
          PH_FILL: hdrByte = OP_FILL;
          PH_PROG: hdrByte = OP_PROG;
          default: hdrByte = OP_CMP;
        endcase
      end
      2'd1:    hdrByte = frameAddr[23:16];
      2'd2:    hdrByte = frameAddr[15:8];
      default: hdrByte = (st.phase == PH_PROG) ? frameAddr[7:0] : 8'h00;
    endcase
  end

  always_comb begin
    unique case (st.sel)
      SEL_HDR:  spiByte = hdrByte;
      SEL_DATA: spiByte = wrData;
      SEL_SOP:  spiByte = OP_STAT;
      default:  spiByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo <= '0; rem <= '0; divCnt <= '0; remain <= '0; written <= '0;
      dataCnt <= '0; hdrIdx <= '0; ioErr <= 1'b0; rangeErr <= 1'b0; failPage <= '0;
    end else begin
      if (st.load) begin
        quo <= startAddr; rem <= '0; divCnt <= '0; remain <= reqLen; written <= '0;
        ioErr <= 1'b0; rangeErr <= 1'b0; failPage <= '0;
      end
      if (st.setRangeErr) rangeErr <= 1'b1;
      if (st.divRun) begin   // one restoring-division step per cycle
        divCnt <= divCnt + 1'b1;
        quo    <= {quo[LEN_W-2:0], takeBit};
        rem    <= takeBit ? PSZ_W'(trial - {1'b0, pageSize}) : trial[PSZ_W-1:0];
      end
      if (st.hdrClr) begin
        hdrIdx  <= '0;
        dataCnt <= chunk;
      end
      if (st.hdrNext)  hdrIdx  <= hdrIdx + 1'b1;
      if (st.dataNext) dataCnt <= dataCnt - 1'b1;
      if (st.pageAdv) begin
        quo     <= quo + 1'b1;
        rem     <= '0;
        remain  <= remain - LEN_W'(chunk);
        written <= written + LEN_W'(chunk);
      end
      if (st.setIoErr) begin
        ioErr    <= 1'b1;
        failPage <= quo;
      end
    end
  end

  // R10: the success count never moves in the cycle an error is recorded
  a_r10_count_frozen_on_err: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioErr) |-> $stable(written));
endmodule

// File: rtl/dfprog_ctrl.sv
module dfprog_ctrl
  import dfprog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       verifyEn,
  input  logic       wrValid,
  input  logic       spiAck,
  input  logic [7:0] spiRx,
  input  logic       isZero,
  input  logic       isOver,
  input  logic       divDone,
  input  logic       partial,
  input  logic       lastChunk,
  input  logic       lastHdr,
  input  logic       lastData,
  output strobe_t    st,
  output logic       spiReq,
  output logic       spiLast,
  output logic       wrReady,
  output logic       busy,
  output logic       done
);
  state_t state, stateN;
  phase_t phase, phaseN;
  logic   verReg;

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);

  always_comb begin
    st = '0;
    st.phase = phase;
    st.sel   = SEL_HDR;
    stateN  = state;
    phaseN  = phase;
    spiReq  = 1'b0;
    spiLast = 1'b0;
    wrReady = 1'b0;
    unique case (state)
      S_IDLE: if (start) begin
        st.load = 1'b1;
        if (isZero)      stateN = S_FIN;
        else if (isOver) begin st.setRangeErr = 1'b1; stateN = S_FIN; end
        else             stateN = S_DIV;
      end
      S_DIV: begin
        st.divRun = !divDone;
        if (divDone) stateN = S_PLAN;
      end
      S_PLAN: begin
        phaseN    = partial ? PH_FILL : PH_PROG;
        st.hdrClr = 1'b1;
        stateN    = S_HDR;
      end
      S_HDR: begin
        spiReq  = 1'b1;
        spiLast = lastHdr && (phase != PH_PROG);
        if (spiAck) begin
          st.hdrNext = 1'b1;
          if (lastHdr) stateN = (phase == PH_PROG) ? S_DATA : S_POP;
        end
      end
      S_DATA: begin
        st.sel  = SEL_DATA;
        spiReq  = wrValid;
        spiLast = lastData;
        wrReady = spiAck;
        if (spiAck) begin
          st.dataNext = 1'b1;
          if (lastData) stateN = S_POP;
        end
      end
      S_POP: begin
        st.sel = SEL_SOP;
        spiReq = 1'b1;
        if (spiAck) stateN = S_PRD;
      end
      S_PRD: begin
        st.sel  = SEL_SRD;
        spiReq  = 1'b1;
        spiLast = 1'b1;
        if (spiAck) begin
          if (!spiRx[7]) stateN = S_POP;
          else if (phase == PH_FILL) begin
            phaseN = PH_PROG; st.hdrClr = 1'b1; stateN = S_HDR;
          end else if (phase == PH_PROG && verReg) begin
            phaseN = PH_CMP; st.hdrClr = 1'b1; stateN = S_HDR;
          end else if (phase == PH_CMP && spiRx[6]) begin
            st.setIoErr = 1'b1; stateN = S_FIN;
          end else begin
            st.pageAdv = 1'b1;
            stateN = lastChunk ? S_FIN : S_PLAN;
          end
        end
      end
      default: stateN = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      phase  <= PH_FILL;
      verReg <= 1'b0;
    end else begin
      state <= stateN;
      phase <= phaseN;
      if (st.load) verReg <= verifyEn;
    end
  end

  // R6: a new command header only follows a status poll that returned ready
  a_r6_cmd_after_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HDR && $past(state) == S_PRD) |-> $past(spiRx[7]));
  // R11: payload is taken only while its byte is being acknowledged
  a_r11_take_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    wrReady |-> (spiReq && spiAck && wrValid));
endmodule

// File: rtl/dfprog_seq.sv
module dfprog_seq
  import dfprog_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int PSZ_W = 12,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] startAddr,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [LEN_W-1:0] devSize,
  input  logic [PSZ_W-1:0] pageSize,
  input  logic [SH_W-1:0]  pageShift,
  input  logic             verifyEn,
  input  logic [7:0]       wrData,
  input  logic             wrValid,
  output logic             wrReady,
  output logic             spiReq,
  output logic [7:0]       spiByte,
  output logic             spiLast,
  input  logic             spiAck,
  input  logic [7:0]       spiRx,
  output logic             busy,
  output logic             done,
  output logic             rangeErr,
  output logic             ioErr,
  output logic [LEN_W-1:0] failPage,
  output logic [LEN_W-1:0] bytesWritten
);
  strobe_t st;
  logic isZero, isOver, divDone, partial, lastChunk, lastHdr, lastData;

  dfprog_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .verifyEn(verifyEn), .wrValid(wrValid),
    .spiAck(spiAck), .spiRx(spiRx), .isZero(isZero), .isOver(isOver),
    .divDone(divDone), .partial(partial), .lastChunk(lastChunk), .lastHdr(lastHdr),
    .lastData(lastData), .st(st), .spiReq(spiReq), .spiLast(spiLast),
    .wrReady(wrReady), .busy(busy), .done(done)
  );

  dfprog_dpath #(.LEN_W(LEN_W), .PSZ_W(PSZ_W), .SH_W(SH_W)) u_dpath (
    .clk(clk), .rstN(rstN), .st(st), .startAddr(startAddr), .reqLen(reqLen),
    .devSize(devSize), .pageSize(pageSize), .pageShift(pageShift), .wrData(wrData),
    .spiByte(spiByte), .isZero(isZero), .isOver(isOver), .divDone(divDone),
    .partial(partial), .lastChunk(lastChunk), .lastHdr(lastHdr), .lastData(lastData),
    .ioErr(ioErr), .rangeErr(rangeErr), .failPage(failPage), .bytesWritten(bytesWritten)
  );

  // R1: empty request completes at once with nothing counted
  a_r1_zero_done: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && reqLen == '0) |=> (done && !rangeErr && bytesWritten == '0));
  // R2: out-of-range request is refused on the next cycle
  a_r2_range_reject: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && reqLen != '0 &&
     (({1'b0, startAddr} + {1'b0, reqLen}) > {1'b0, devSize})) |=> (done && rangeErr));
  // R8: a compare failure ends the request in the same cycle it is flagged
  a_r8_err_ends: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioErr) |-> done);
  // R12: a pending byte request is held steady until acknowledged
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (spiReq && !spiAck) |=> (spiReq && $stable(spiByte) && $stable(spiLast)));
endmodule

// File: tb/tb_dfprog_seq.sv
module tb_dfprog_seq;
  localparam int LEN_W = 24;
  localparam int PSZ_W = 12;
  localparam int SH_W  = 4;
  localparam int NV    = 8;
  localparam int MAXF  = 64;

  typedef struct packed {
    int start; int len; int psz; int sh; int dev; int ver; int failPg;
  } vec_t;

  // start, len, pageSize, shift, devSize, verify, failing page (-1 none)
  localparam vec_t VECS [NV] = '{
    '{100,    50,  264, 9, 540672, 1, -1},
    '{792,    528, 264, 9, 540672, 1, -1},
    '{200,    400, 264, 9, 540672, 1, -1},
    '{200,    400, 264, 9, 540672, 0, -1},
    '{200,    400, 264, 9, 540672, 1,  1},
    '{250,    6,   16,  8, 256,    1, -1},
    '{5,      40,  16,  8, 256,    1,  2},
    '{540372, 300, 264, 9, 540672, 1, -1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, start, verifyEn, wrValid, wrReady, spiReq, spiLast, spiAck;
  logic busy, done, rangeErr, ioErr;
  logic [LEN_W-1:0] startAddr, reqLen, devSize, failPage, bytesWritten;
  logic [PSZ_W-1:0] pageSize;
  logic [SH_W-1:0]  pageShift;
  logic [7:0] wrData, spiByte, spiRx;

  dfprog_seq #(.LEN_W(LEN_W), .PSZ_W(PSZ_W), .SH_W(SH_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .reqLen(reqLen),
    .devSize(devSize), .pageSize(pageSize), .pageShift(pageShift), .verifyEn(verifyEn),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady), .spiReq(spiReq),
    .spiByte(spiByte), .spiLast(spiLast), .spiAck(spiAck), .spiRx(spiRx), .busy(busy),
    .done(done), .rangeErr(rangeErr), .ioErr(ioErr), .failPage(failPage),
    .bytesWritten(bytesWritten)
  );

  int nChecks = 0, nErr = 0;

  // flash model state
  int pos, nLog, dataSeen, dataErr, seqErr, busyLeft, cmpPage, failPgM, shM, byteIdx;
  bit devBusy, lastCmp, takeNext;
  logic [7:0]  curOp;
  logic [23:0] curAddr;
  logic [7:0]  logOp   [MAXF];
  logic [23:0] logAddr [MAXF];
  int          logLen  [MAXF];
  // expected frames
  int          nExp, expWritten, expFailPage;
  bit          expIoErr;
  logic [7:0]  expOp   [MAXF];
  logic [23:0] expAddr [MAXF];
  int          expLen  [MAXF];

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Shifter + flash model: acknowledges one byte every other cycle.
  initial begin
    spiAck = 1'b0; spiRx = 8'h00; pos = 0; nLog = 0; devBusy = 0; busyLeft = 0;
    lastCmp = 0; cmpPage = -1; takeNext = 0; dataSeen = 0; dataErr = 0; seqErr = 0;
    byteIdx = 0; wrData = pat(0); curOp = 8'h00; curAddr = '0;
    forever begin
      @(negedge clk);
      if (takeNext) begin byteIdx++; wrData = pat(byteIdx); takeNext = 0; end
      if (spiAck) spiAck = 1'b0;
      else if (spiReq && rstN) begin
        spiRx = 8'h00;
        if (pos == 0) begin
          curOp = spiByte; curAddr = '0;
          if (spiByte != 8'hD7 && devBusy) seqErr++;
        end else if (pos <= 3) begin
          curAddr = {curAddr[15:0], spiByte};
          if (curOp == 8'hD7 && pos == 1) begin
            if (busyLeft > 0) begin spiRx = 8'h6C; busyLeft--; end
            else begin
              spiRx = (lastCmp && cmpPage == failPgM) ? 8'hEC : 8'hAC;
              devBusy = 0;
            end
          end
        end else begin
          if (spiByte != pat(dataSeen)) dataErr++;
          dataSeen++;
        end
        if (spiLast) begin
          if (curOp != 8'hD7) begin
            if (nLog < MAXF) begin
              logOp[nLog] = curOp; logAddr[nLog] = curAddr; logLen[nLog] = pos + 1;
            end
            nLog++;
            devBusy = 1; busyLeft = 2;
            lastCmp = (curOp == 8'h60);
            cmpPage = int'(curAddr >> shM);
          end
          pos = 0;
        end else pos++;
        spiAck = 1'b1;
        #1 takeNext = wrReady;
      end
    end
  end

  task automatic pushExp(input logic [7:0] op, input int addr, input int len);
    if (nExp < MAXF) begin
      expOp[nExp] = op; expAddr[nExp] = 24'(addr); expLen[nExp] = len;
    end
    nExp++;
  endtask

  task automatic buildExp(input vec_t v);
    int page, off, rem, chunk, base;
    nExp = 0; expWritten = 0; expIoErr = 0; expFailPage = 0;
    if (v.len == 0 || v.start + v.len > v.dev) return;
    page = v.start / v.psz; off = v.start % v.psz; rem = v.len;
    while (rem > 0) begin
      chunk = (rem < v.psz - off) ? rem : v.psz - off;
      base  = page << v.sh;
      if (chunk != v.psz) pushExp(8'h53, base, 4);
      pushExp(8'h82, base + off, 4 + chunk);
      if (v.ver != 0) begin
        pushExp(8'h60, base, 4);
        if (page == v.failPg) begin expIoErr = 1; expFailPage = page; break; end
      end
      expWritten += chunk; rem -= chunk; page++; off = 0;
    end
  endtask

  task automatic doRun(input vec_t v, output int cyc);
    @(negedge clk);
    nLog = 0; pos = 0; dataSeen = 0; dataErr = 0; seqErr = 0; devBusy = 0; busyLeft = 0;
    lastCmp = 0; byteIdx = 0; wrData = pat(0); takeNext = 0;
    failPgM = v.failPg; shM = v.sh;
    startAddr = LEN_W'(v.start); reqLen = LEN_W'(v.len); devSize = LEN_W'(v.dev);
    pageSize = PSZ_W'(v.psz); pageShift = SH_W'(v.sh); verifyEn = (v.ver != 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    if (!done) begin
      chk(1'b0, "R12", "watchdog expired", cyc, 0);
      rstN = 1'b0; repeat (2) @(negedge clk); rstN = 1'b1;
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int cyc, nCmp;
    string rq;
    buildExp(v);
    doRun(v, cyc);
    chk(nLog == nExp, "R3", $sformatf("vec%0d frame count", idx), nLog, nExp);
    for (int i = 0; i < nExp && i < nLog && i < MAXF; i++) begin
      rq = (expOp[i] == 8'h53) ? "R4" : (expOp[i] == 8'h82) ? "R5" : "R7";
      chk(logOp[i] == expOp[i], rq, $sformatf("vec%0d frame%0d opcode", idx, i), logOp[i], expOp[i]);
      chk(logAddr[i] == expAddr[i], rq, $sformatf("vec%0d frame%0d address", idx, i), logAddr[i], expAddr[i]);
      chk(logLen[i] == expLen[i], "R3", $sformatf("vec%0d frame%0d length", idx, i), logLen[i], expLen[i]);
    end
    chk(int'(bytesWritten) == expWritten, "R10", $sformatf("vec%0d bytesWritten", idx), bytesWritten, expWritten);
    chk(ioErr == expIoErr, "R8", $sformatf("vec%0d ioErr", idx), ioErr, expIoErr);
    if (expIoErr) chk(int'(failPage) == expFailPage, "R8", $sformatf("vec%0d failPage", idx), failPage, expFailPage);
    chk(rangeErr == 1'b0, "R2", $sformatf("vec%0d rangeErr", idx), rangeErr, 0);
    chk(dataErr == 0, "R11", $sformatf("vec%0d payload order errors", idx), dataErr, 0);
    chk(seqErr == 0, "R6", $sformatf("vec%0d command while busy", idx), seqErr, 0);
    chk(pos == 0, "R12", $sformatf("vec%0d open frame at end", idx), pos, 0);
    if (v.ver == 0) begin
      nCmp = 0;
      for (int i = 0; i < nLog && i < MAXF; i++) if (logOp[i] == 8'h60) nCmp++;
      chk(nCmp == 0, "R9", $sformatf("vec%0d compare frames", idx), nCmp, 0);
    end
  endtask

  initial begin
    int cyc;
    vec_t z;
    rstN = 1'b0; start = 1'b0; wrValid = 1'b1; verifyEn = 1'b1;
    startAddr = '0; reqLen = '0; devSize = '0; pageSize = '0; pageShift = '0;
    repeat (3) @(negedge clk);
    chk(spiReq == 1'b0, "R12", "reset spiReq", spiReq, 0);
    chk(busy == 1'b0 && done == 1'b0, "R12", "reset busy/done", {busy, done}, 0);
    chk(bytesWritten == '0 && !ioErr && !rangeErr, "R10", "reset results", bytesWritten, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R1: zero length
    z = '{300, 0, 264, 9, 540672, 1, -1};
    doRun(z, cyc);
    chk(cyc == 0, "R1", "zero-length wait cycles", cyc, 0);
    chk(nLog == 0, "R1", "zero-length frames", nLog, 0);
    chk(bytesWritten == '0 && !rangeErr && !ioErr, "R1", "zero-length results", bytesWritten, 0);

    // R2: one byte past the end
    z = '{250, 7, 16, 8, 256, 1, -1};
    doRun(z, cyc);
    chk(cyc == 0, "R2", "range wait cycles", cyc, 0);
    chk(rangeErr == 1'b1, "R2", "range flag", rangeErr, 1);
    chk(nLog == 0, "R2", "range frames", nLog, 0);
    chk(bytesWritten == '0, "R2", "range bytesWritten", bytesWritten, 0);

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule